// File: doc/BRIEF.md
# Key-Locked Commit Register Gate

This block guards a per-pin configuration register, the alternate-function select, so that stray software writes cannot change it. Protection works in two stages. A lock flag comes out of reset set. Software clears it by writing one exact 32-bit key to the lock register. While the flag is clear, software can load an 8-bit commit mask. The mask then decides, bit by bit, which pins of the protected register a later write may change. Pins whose mask bit is zero keep their value whatever is written.

All three registers sit on a simple register bus with an address, a write strobe and write data. Read data is combinational from the address. The protected register value is also driven out continuously to the pad logic. Every accepted write takes effect on the next rising clock edge.

Top module: `pinmux_commit_gate`

## Requirements
- R1: After reset the lock register (offset 0x520) reads 1, the commit register (offset 0x524) reads 0xFF, and the protected register (offset 0x420) and `altfn_o` are 0.
- R2: A write of exactly 0x0ACCE551 to the lock register makes it read 0 from the next clock edge on.
- R3: A write of any other 32-bit value to the lock register, including one that differs from the key in a single bit, makes it read 1 from the next clock edge on.
- R4: A write to the commit register while the lock reads 1 leaves the commit register unchanged.
- R5: A write to the commit register while the lock reads 0 loads bits 7:0 of the write data. Bits 31:8 are discarded and always read back as 0.
- R6: A write to the protected register changes exactly those bits that are set in the commit register. Every other bit keeps its value.
- R7: A commit write does not change the lock state. The lock only returns to 1 through a non-key lock write.
- R8: A written value is not visible in readback or on `altfn_o` before the clock edge that accepts the write, and it is visible right after that edge.
- R9: Writes to any other address change none of the three registers, and reads of any other address return 0.
- R10: A read of offset 0x420 returns the same value that `altfn_o` drives, zero-extended to 32 bits.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| bus_wr | input | 1 | Write strobe, one write per high cycle |
| bus_addr | input | 12 | Byte offset used for both read and write |
| bus_wdata | input | 32 | Write data |
| rd_data | output | 32 | Combinational read data for `bus_addr` |
| altfn_o | output | 8 | Protected alternate-function select for the pads |

## Verification
A lock flag stuck in the wrong state shows up within one cycle. The lock readback at 0x520 reports it directly. It also shows as a commit write that was wrongly taken or wrongly dropped, which can be seen on the next read of 0x524. A corrupted commit mask appears on the first protected-register write after it. Some pins then move that should hold, or hold when they should move, and this is visible on `altfn_o` one edge after the write. Because of this, the directed tests always follow a mask change with a protected write and a readback.

// File: rtl/gate_pkg.sv
package gate_pkg;
    typedef enum logic [1:0] {
        SEL_NONE   = 2'd0,
        SEL_LOCK   = 2'd1,
        SEL_COMMIT = 2'd2,
        SEL_ALTFN  = 2'd3
    } reg_sel_e;
endpackage

// File: rtl/gate_decode.sv
module gate_decode
    import gate_pkg::*;
#(
    parameter int ADDR_W     = 12,
    parameter int LOCK_OFF   = 12'h520,
    parameter int COMMIT_OFF = 12'h524,
    parameter int ALTFN_OFF  = 12'h420
) (
    input  logic [ADDR_W-1:0] addr,
    output reg_sel_e          sel
);
    always_comb begin
        if (addr == ADDR_W'(LOCK_OFF))        sel = SEL_LOCK;
        else if (addr == ADDR_W'(COMMIT_OFF)) sel = SEL_COMMIT;
        else if (addr == ADDR_W'(ALTFN_OFF))  sel = SEL_ALTFN;
        else                                  sel = SEL_NONE;
    end
endmodule

// File: rtl/gate_lock.sv
module gate_lock #(
    parameter int          DATA_W = 32,
    parameter logic [31:0] KEY    = 32'h0ACCE551
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              we,
    input  logic [DATA_W-1:0] wdata,
    output logic              locked
);
    typedef struct packed {
        logic locked;
    } lock_state_t;

    lock_state_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        if (we) st_d.locked = (wdata != DATA_W'(KEY));
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q.locked <= 1'b1;
        else        st_q <= st_d;
    end

    assign locked = st_q.locked;
endmodule

// File: rtl/gate_bitreg.sv
module gate_bitreg #(
    parameter int           W   = 8,
    parameter logic [W-1:0] RST = '0
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         we,
    input  logic [W-1:0] wmask,
    input  logic [W-1:0] wdata,
    output logic [W-1:0] q
);
    typedef struct packed {
        logic [W-1:0] val;
    } bit_state_t;

    bit_state_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        if (we) st_d.val = (st_q.val & ~wmask) | (wdata & wmask);
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q.val <= RST;
        else        st_q <= st_d;
    end

    assign q = st_q.val;
endmodule

// File: rtl/pinmux_commit_gate.sv
module pinmux_commit_gate
    import gate_pkg::*;
#(
    parameter int          ADDR_W     = 12,
    parameter int          DATA_W     = 32,
    parameter int          PIN_W      = 8,
    parameter logic [31:0] KEY        = 32'h0ACCE551,
    parameter int          LOCK_OFF   = 12'h520,
    parameter int          COMMIT_OFF = 12'h524,
    parameter int          ALTFN_OFF  = 12'h420
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              bus_wr,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic [DATA_W-1:0] bus_wdata,
    output logic [DATA_W-1:0] rd_data,
    output logic [PIN_W-1:0]  altfn_o
);
    localparam logic [PIN_W-1:0] ALL_PINS = {PIN_W{1'b1}};

    reg_sel_e         sel;
    logic             lock_q;
    logic [PIN_W-1:0] cmask_q;
    logic [PIN_W-1:0] wpins;

    assign wpins = bus_wdata[PIN_W-1:0];

    gate_decode #(
        .ADDR_W(ADDR_W), .LOCK_OFF(LOCK_OFF),
        .COMMIT_OFF(COMMIT_OFF), .ALTFN_OFF(ALTFN_OFF)
    ) u_dec (
        .addr(bus_addr),
        .sel (sel)
    );

    gate_lock #(.DATA_W(DATA_W), .KEY(KEY)) u_lock (
        .clk   (clk),
        .rst_n (rst_n),
        .we    (bus_wr && (sel == SEL_LOCK)),
        .wdata (bus_wdata),
        .locked(lock_q)
    );

    gate_bitreg #(.W(PIN_W), .RST(ALL_PINS)) u_commit (
        .clk  (clk),
        .rst_n(rst_n),
        .we   (bus_wr && (sel == SEL_COMMIT) && !lock_q),
        .wmask(ALL_PINS),
        .wdata(wpins),
        .q    (cmask_q)
    );

    gate_bitreg #(.W(PIN_W), .RST('0)) u_altfn (
        .clk  (clk),
        .rst_n(rst_n),
        .we   (bus_wr && (sel == SEL_ALTFN)),
        .wmask(cmask_q),
        .wdata(wpins),
        .q    (altfn_o)
    );

    always_comb begin
        unique case (sel)
            SEL_LOCK:   rd_data = DATA_W'(lock_q);
            SEL_COMMIT: rd_data = DATA_W'(cmask_q);
            SEL_ALTFN:  rd_data = DATA_W'(altfn_o);
            default:    rd_data = '0;
        endcase
    end
endmodule

// File: rtl/gate_chk.sv
module gate_chk #(
    parameter int          ADDR_W     = 12,
    parameter int          DATA_W     = 32,
    parameter int          PIN_W      = 8,
    parameter logic [31:0] KEY        = 32'h0ACCE551,
    parameter int          LOCK_OFF   = 12'h520,
    parameter int          COMMIT_OFF = 12'h524,
    parameter int          ALTFN_OFF  = 12'h420
) (
    input logic              clk,
    input logic              rst_n,
    input logic              bus_wr,
    input logic [ADDR_W-1:0] bus_addr,
    input logic [DATA_W-1:0] bus_wdata,
    input logic [PIN_W-1:0]  altfn_o,
    input logic              lock_q,
    input logic [PIN_W-1:0]  cmask_q
);
    logic wr_lock, wr_commit, wr_altfn;
    assign wr_lock   = bus_wr && bus_addr == ADDR_W'(LOCK_OFF);
    assign wr_commit = bus_wr && bus_addr == ADDR_W'(COMMIT_OFF);
    assign wr_altfn  = bus_wr && bus_addr == ADDR_W'(ALTFN_OFF);

    // R2
    key_unlock_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_lock && bus_wdata == DATA_W'(KEY)) |=> !lock_q);

    // R3
    bad_key_relock_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_lock && bus_wdata != DATA_W'(KEY)) |=> lock_q);

    // R4
    locked_commit_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (lock_q && !wr_commit) || (lock_q && wr_commit) |=> $stable(cmask_q));

    // R6
    masked_update_chk: assert property (@(posedge clk) disable iff (!rst_n)
        wr_altfn |=> ((altfn_o ^ $past(altfn_o)) & ~$past(cmask_q)) == '0
                  && ((altfn_o ^ $past(bus_wdata[PIN_W-1:0])) & $past(cmask_q)) == '0);

    // R7
    commit_keeps_lock_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !wr_lock |=> $stable(lock_q));

    // R9
    altfn_only_by_write_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !wr_altfn |=> $stable(altfn_o));
endmodule

bind pinmux_commit_gate gate_chk #(
    .ADDR_W(ADDR_W), .DATA_W(DATA_W), .PIN_W(PIN_W), .KEY(KEY),
    .LOCK_OFF(LOCK_OFF), .COMMIT_OFF(COMMIT_OFF), .ALTFN_OFF(ALTFN_OFF)
) u_gate_chk (
    .clk      (clk),
    .rst_n    (rst_n),
    .bus_wr   (bus_wr),
    .bus_addr (bus_addr),
    .bus_wdata(bus_wdata),
    .altfn_o  (altfn_o),
    .lock_q   (lock_q),
    .cmask_q  (cmask_q)
);

// File: tb/tb_pinmux_commit_gate.sv
module tb_pinmux_commit_gate;
    localparam logic [11:0] A_LOCK = 12'h520;
    localparam logic [11:0] A_CMT  = 12'h524;
    localparam logic [11:0] A_ALT  = 12'h420;
    localparam logic [31:0] KEYV   = 32'h0ACCE551;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        bus_wr = 1'b0;
    logic [11:0] bus_addr = '0;
    logic [31:0] bus_wdata = '0;
    logic [31:0] rd_data;
    logic [7:0]  altfn_o;

    int n_run = 0;
    int n_fail = 0;

    pinmux_commit_gate dut (
        .clk(clk), .rst_n(rst_n), .bus_wr(bus_wr), .bus_addr(bus_addr),
        .bus_wdata(bus_wdata), .rd_data(rd_data), .altfn_o(altfn_o)
    );

    always #10 clk = ~clk;

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_run++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic wr(input logic [11:0] a, input logic [31:0] d);
        @(negedge clk);
        bus_wr = 1'b1; bus_addr = a; bus_wdata = d;
        @(negedge clk);
        bus_wr = 1'b0;
    endtask

    task automatic rd(input logic [11:0] a, output logic [31:0] d);
        bus_addr = a;
        #1 d = rd_data;
    endtask

    task automatic t_reset;
        logic [31:0] v;
        rd(A_LOCK, v); check("R1 lock", v, 32'h1);
        rd(A_CMT, v);  check("R1 commit", v, 32'hFF);
        rd(A_ALT, v);  check("R1 altfn", v, 32'h0);
        check("R1 altfn_o", {24'h0, altfn_o}, 32'h0);
    endtask

    task automatic t_unlock_timing;
        logic [31:0] v;
        @(negedge clk);
        bus_wr = 1'b1; bus_addr = A_LOCK; bus_wdata = KEYV;
        #1 check("R8 lock before edge", rd_data, 32'h1);
        @(negedge clk);
        bus_wr = 1'b0;
        rd(A_LOCK, v); check("R2 unlocked", v, 32'h0);
    endtask

    task automatic t_bad_keys;
        logic [31:0] v;
        wr(A_LOCK, KEYV ^ 32'h0000_0001);
        rd(A_LOCK, v); check("R3 one-bit-off key", v, 32'h1);
        wr(A_LOCK, KEYV);
        wr(A_LOCK, KEYV ^ 32'h8000_0000);
        rd(A_LOCK, v); check("R3 top bit off", v, 32'h1);
        wr(A_LOCK, 32'h0);
        rd(A_LOCK, v); check("R3 zero", v, 32'h1);
    endtask

    task automatic t_commit_locked;
        logic [31:0] v;
        wr(A_CMT, 32'h0000_0012);
        rd(A_CMT, v); check("R4 commit ignored", v, 32'hFF);
    endtask

    task automatic t_commit_unlocked;
        logic [31:0] v;
        wr(A_LOCK, KEYV);
        wr(A_CMT, 32'hABCD_5A0F);
        rd(A_CMT, v);  check("R5 low byte only", v, 32'h0F);
        rd(A_LOCK, v); check("R7 still unlocked", v, 32'h0);
        wr(A_CMT, 32'h0000_00F0);
        rd(A_LOCK, v); check("R7 still unlocked 2", v, 32'h0);
        wr(A_LOCK, 32'h1234_5678);
        rd(A_LOCK, v); check("R7 relocked", v, 32'h1);
        wr(A_CMT, 32'h0000_00FF);
        rd(A_CMT, v);  check("R4 locked again", v, 32'hF0);
    endtask

    task automatic t_masked_altfn;
        logic [31:0] v;
        // mask is 0xF0 here, altfn is 0x00
        wr(A_ALT, 32'hFFFF_FFFF);
        rd(A_ALT, v); check("R6 upper nibble set", v, 32'hF0);
        check("R10 port matches", {24'h0, altfn_o}, v);
        wr(A_ALT, 32'h0000_005A);
        rd(A_ALT, v); check("R6 mixed", v, 32'h50);
        wr(A_LOCK, KEYV);
        wr(A_CMT, 32'h0000_0000);
        wr(A_ALT, 32'h0000_00AF);
        rd(A_ALT, v); check("R6 zero mask holds", v, 32'h50);
        wr(A_CMT, 32'h0000_003C);
        wr(A_ALT, 32'h0000_00C3);
        rd(A_ALT, v); check("R6 middle bits", v, 32'h40);
        check("R10 port matches 2", {24'h0, altfn_o}, 32'h40);
    endtask

    task automatic t_alt_timing;
        wr(A_CMT, 32'h0000_00FF);
        @(negedge clk);
        bus_wr = 1'b1; bus_addr = A_ALT; bus_wdata = 32'h0000_0081;
        #1 check("R8 altfn_o before edge", {24'h0, altfn_o}, 32'h40);
        @(negedge clk);
        bus_wr = 1'b0;
        #1 check("R8 altfn_o after edge", {24'h0, altfn_o}, 32'h81);
    endtask

    task automatic t_other_addr;
        logic [31:0] v;
        wr(12'h41C, 32'h0000_0000);
        wr(12'h528, 32'h0000_0000);
        wr(12'h000, 32'hFFFF_FFFF);
        rd(A_LOCK, v); check("R9 lock unchanged", v, 32'h0);
        rd(A_CMT, v);  check("R9 commit unchanged", v, 32'hFF);
        rd(A_ALT, v);  check("R9 altfn unchanged", v, 32'h81);
        rd(12'h400, v); check("R9 unmapped read", v, 32'h0);
        rd(12'hFFC, v); check("R9 unmapped read 2", v, 32'h0);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        t_reset();
        t_unlock_timing();
        t_bad_keys();
        t_commit_locked();
        t_commit_unlocked();
        t_masked_altfn();
        t_alt_timing();
        t_other_addr();
        $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    end

    initial begin
        #200000;
        n_run++;
        n_fail++;
        $display("FAIL watchdog actual=timeout expected=done");
        $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    end
endmodule